// File: doc/BRIEF.md
# Flash Read Line Buffer Controller with Next-Line Prefetch

This block keeps the tags and per-buffer states for a small set of read line buffers (four by default) that front a slow flash array. Each bus read is compared against the held line tags. A read that matches a held line is answered from the buffer on the next cycle. A read that matches nothing allocates a buffer and sends a fill request to the array. The read is answered once the array reports the fill complete. After a read completes, the controller may send a speculative fill for the next sequential line. Whether it does depends on the configured prefetch policy, the access type and the requesting master.

Replacement uses empty buffers first, lowest index first. When no buffer is empty, it uses the least-recently-used buffer that is not busy. A line loaded by a demand miss moves to the front of the recency order at once. A speculatively loaded line keeps its recency position until a later read hits it. Only one array fill is in flight at a time. The array timing and the data payload sit outside the block. The controller sees only the fill request and a one-cycle fill-done strobe.

Top module: `flbuf_ctrl`

## Requirements
- R1: A read whose line is held in a buffer in state Used, Valid, Prefetched or Busy-bus raises `req_ready` exactly one cycle after it is accepted, with `resp_hit`=1, and issues no fill request.
- R2: A read miss while any buffer is Invalid fills the lowest-numbered Invalid buffer (`fill_buf`), with `fill_pf`=0 and `fill_line` equal to the request line.
- R3: A read miss with no Invalid buffer replaces the least-recently-used buffer among those not in Busy-fill or Busy-bus. The recency order is a permutation of buffer indices, and index 0 is the oldest after reset.
- R4: A demand fill makes its buffer most-recently-used when the fill completes. `req_ready` rises in the cycle after `fill_done`, with `resp_hit`=0.
- R5: A buffer loaded by prefetch keeps its recency position until a read hits it. The hit makes it most-recently-used.
- R6: A prefetch fill (`fill_pf`=1, `fill_line` = request line + 1 modulo 2^LINE_W) is issued in the cycle after the response, and only when all of the following hold:
  - `cfg_buf_en`=1;
  - the access-type enable is set (`cfg_ipf_en` for `req_instr`=1, `cfg_dpf_en` otherwise);
  - `cfg_master_pf[req_master]`=1;
  - `cfg_pf_limit` allows it: 0 never, 1 only after a miss, 2 or 3 after a miss or a hit.
- R7: A write is acknowledged one cycle after acceptance with `resp_hit`=0 and never causes a fill or prefetch. It returns a matching non-busy buffer to Invalid.
- R8: A read that hits a line still in Busy-fill issues no second fill. It answers with `resp_hit`=1 in the cycle after that fill's `fill_done`.
- R9: A read miss that finds a fill already in flight, or no replaceable buffer, holds `req_ready` low and issues no fill until the condition clears.
- R10: With `cfg_buf_en`=0, every read is sent to the array (`fill_pf`=0) and answered after `fill_done` with `resp_hit`=0. All buffers become Invalid, so after re-enabling, misses fill buffers 0, 1, 2 and so on.
- R11: A burst read leaves its buffer in Busy-bus, where it cannot be replaced, until a `burst_end` pulse turns it into Used.
- R12: After reset, `req_ready` and `fill_req` are low, all buffers are Invalid, and `req_ready` is never high for two cycles in a row.
- R13: No prefetch is issued when the next line is already held in a buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held with its fields until `req_ready` |
| req_line | input | LINE_W | Line address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | 1 = instruction access, 0 = data access |
| req_burst | input | 1 | 1 = burst read, 0 = single read |
| req_master | input | MID_W | Requesting master number |
| burst_end | input | 1 | Pulse: current bursts are over, Busy-bus buffers become Used |
| cfg_buf_en | input | 1 | Global buffer enable |
| cfg_pf_limit | input | 2 | Prefetch policy: 0 off, 1 after miss, 2/3 after miss or hit |
| cfg_ipf_en | input | 1 | Prefetch enable for instruction reads |
| cfg_dpf_en | input | 1 | Prefetch enable for data reads |
| cfg_master_pf | input | 2**MID_W | Per-master prefetch enable, indexed by `req_master` |
| fill_done | input | 1 | One-cycle strobe: the fill in flight has completed |
| req_ready | output | 1 | One-cycle response strobe for the held request |
| resp_hit | output | 1 | Qualifies `req_ready`: 1 when the read was served by a buffer |
| fill_req | output | 1 | One-cycle array fill request |
| fill_line | output | LINE_W | Line address to fetch |
| fill_buf | output | $clog2(NBUF) | Buffer receiving the fill |
| fill_pf | output | 1 | 1 when the fill is a speculative prefetch |

## Verification
The hardest cases to reach are a read that lands on a line whose speculative fill is still in flight, and a miss that finds every buffer busy. The bench reaches the first by sending the next-line read straight after the response that triggered the prefetch, before the array model returns the strobe. It reaches the second by holding four burst reads open with no `burst_end`, then presenting a miss and releasing the bursts only after a long observation window. The recency rules are exposed through which buffer the next replacement picks. A bench-side model of tags and recency predicts every fill across a sweep of prefetch policies, access types, masters and sequential address runs.

// File: rtl/flbuf_pkg.sv
package flbuf_pkg;

    typedef enum logic [2:0] {
        BS_INVALID,
        BS_USED,
        BS_VALID,
        BS_PREFETCHED,
        BS_BUSY_BUS,
        BS_BUSY_FILL
    } buf_state_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_WAIT,
        FS_PF_CHECK
    } fsm_e;

    typedef struct packed {
        logic       write;
        logic       instr;
        logic       burst;
    } req_kind_t;

    function automatic logic is_busy(buf_state_e s);
        return (s == BS_BUSY_BUS) || (s == BS_BUSY_FILL);
    endfunction

    function automatic buf_state_e serve_state(logic burst);
        return burst ? BS_BUSY_BUS : BS_VALID;
    endfunction

    // Prefetch gate: enable, policy field, access type, write exclusion.
    function automatic logic pf_policy_ok(logic buf_en, logic [1:0] limit,
                                          logic ipf, logic dpf,
                                          req_kind_t k, logic was_miss);
        logic type_ok;
        logic lim_ok;
        type_ok = k.instr ? ipf : dpf;
        lim_ok  = (limit == 2'd1) ? was_miss : (limit != 2'd0);
        return buf_en && !k.write && type_ok && lim_ok;
    endfunction

endpackage

// File: rtl/flbuf_lookup.sv
module flbuf_lookup
    import flbuf_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int LINE_W = 8
) (
    input  logic [LINE_W-1:0] key,
    input  logic [LINE_W-1:0] tags   [NBUF],
    input  buf_state_e        states [NBUF],
    output logic              found,
    output logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0] idx
);
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1;

    logic [NBUF-1:0] match;

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_cmp
            assign match[g] = (states[g] != BS_INVALID) && (tags[g] == key);
        end
    endgenerate

    always_comb begin
        found = |match;
        idx   = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (match[i]) idx = IDXW'(i);
        end
    end

endmodule

// File: rtl/flbuf_recency.sv
module flbuf_recency #(
    parameter int NBUF = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                touch,
    input  logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0] touch_idx,
    input  logic [NBUF-1:0]     elig,
    output logic                lru_ok,
    output logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0] lru_idx
);
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1;

    // order_q[0] is the most recent, order_q[NBUF-1] the oldest
    logic [IDXW-1:0] order_q [NBUF];
    logic [IDXW-1:0] order_d [NBUF];

    always_comb begin
        int pos;
        pos = NBUF - 1;
        for (int i = 0; i < NBUF; i++) begin
            if (order_q[i] == touch_idx) pos = i;
        end
        order_d = order_q;
        if (touch) begin
            for (int i = 1; i < NBUF; i++) begin
                if (i <= pos) order_d[i] = order_q[i-1];
            end
            order_d[0] = touch_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) order_q[i] <= IDXW'(NBUF - 1 - i);
        end else begin
            order_q <= order_d;
        end
    end

    // oldest eligible entry wins: scan from the front, keep the last hit
    always_comb begin
        lru_ok  = 1'b0;
        lru_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (elig[order_q[i]]) begin
                lru_ok  = 1'b1;
                lru_idx = order_q[i];
            end
        end
    end

    logic [NBUF-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < NBUF; i++) seen[order_q[i]] = 1'b1;
    end

    a_r3_order_is_permutation: assert property (@(posedge clk) disable iff (rst)
        &seen);

    a_r4_touched_goes_front: assert property (@(posedge clk) disable iff (rst)
        touch |=> order_q[0] == $past(touch_idx));

endmodule

// File: rtl/flbuf_victim.sv
module flbuf_victim
    import flbuf_pkg::*;
#(
    parameter int NBUF = 4
) (
    input  buf_state_e      states [NBUF],
    input  logic            lru_ok,
    input  logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0] lru_idx,
    output logic [NBUF-1:0] elig,
    output logic            vict_ok,
    output logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0] vict_idx
);
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1;

    logic [NBUF-1:0] empty;

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_cls
            assign empty[g] = (states[g] == BS_INVALID);
            assign elig[g]  = !is_busy(states[g]);
        end
    endgenerate

    always_comb begin
        vict_ok  = lru_ok;
        vict_idx = lru_idx;
        if (|empty) begin
            vict_ok = 1'b1;
            for (int i = NBUF - 1; i >= 0; i--) begin
                if (empty[i]) vict_idx = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/flbuf_ctrl.sv
module flbuf_ctrl
    import flbuf_pkg::*;
#(
    parameter int NBUF   = 4,
    parameter int LINE_W = 8,
    parameter int MID_W  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic [LINE_W-1:0]                 req_line,
    input  logic                              req_write,
    input  logic                              req_instr,
    input  logic                              req_burst,
    input  logic [MID_W-1:0]                  req_master,
    input  logic                              burst_end,
    input  logic                              cfg_buf_en,
    input  logic [1:0]                        cfg_pf_limit,
    input  logic                              cfg_ipf_en,
    input  logic                              cfg_dpf_en,
    input  logic [(1<<MID_W)-1:0]             cfg_master_pf,
    input  logic                              fill_done,
    output logic                              req_ready,
    output logic                              resp_hit,
    output logic                              fill_req,
    output logic [LINE_W-1:0]                 fill_line,
    output logic [((NBUF > 1) ? $clog2(NBUF) : 1)-1:0] fill_buf,
    output logic                              fill_pf
);
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1;

    buf_state_e        st_q  [NBUF];
    buf_state_e        st_d  [NBUF];
    logic [LINE_W-1:0] tag_q [NBUF];
    logic [LINE_W-1:0] tag_d [NBUF];

    fsm_e              fsm_q, fsm_d;
    req_kind_t         kind_q, kind_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic [MID_W-1:0]  mid_q, mid_d;
    logic [IDXW-1:0]   cur_buf_q, cur_buf_d;
    logic              miss_q, miss_d;

    // single fill in flight
    logic              pend_q, pend_d;
    logic              pend_pf_q, pend_pf_d;
    logic              byp_q, byp_d;
    logic [IDXW-1:0]   pend_buf_q, pend_buf_d;

    logic              rdy_q, rdy_d, hit_q, hit_d;
    logic              fr_q, fr_d, fp_q, fp_d;
    logic [LINE_W-1:0] fl_q, fl_d;
    logic [IDXW-1:0]   fb_q, fb_d;

    logic              hit_ok, nxt_ok;
    logic [IDXW-1:0]   hit_idx, nxt_idx;
    logic [LINE_W-1:0] nxt_line;
    logic [NBUF-1:0]   elig;
    logic              lru_ok, vict_ok;
    logic [IDXW-1:0]   lru_idx, vict_idx;
    logic              touch;
    logic [IDXW-1:0]   touch_idx;
    logic              pf_go;

    assign nxt_line = line_q + LINE_W'(1);

    flbuf_lookup #(.NBUF(NBUF), .LINE_W(LINE_W)) u_hit_lookup (
        .key(req_line), .tags(tag_q), .states(st_q), .found(hit_ok), .idx(hit_idx)
    );

    flbuf_lookup #(.NBUF(NBUF), .LINE_W(LINE_W)) u_next_lookup (
        .key(nxt_line), .tags(tag_q), .states(st_q), .found(nxt_ok), .idx(nxt_idx)
    );

    flbuf_victim #(.NBUF(NBUF)) u_victim (
        .states(st_q), .lru_ok(lru_ok), .lru_idx(lru_idx),
        .elig(elig), .vict_ok(vict_ok), .vict_idx(vict_idx)
    );

    flbuf_recency #(.NBUF(NBUF)) u_recency (
        .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
        .elig(elig), .lru_ok(lru_ok), .lru_idx(lru_idx)
    );

    assign pf_go = pf_policy_ok(cfg_buf_en, cfg_pf_limit, cfg_ipf_en, cfg_dpf_en,
                                kind_q, miss_q)
                   && cfg_master_pf[mid_q];

    always_comb begin
        st_d       = st_q;
        tag_d      = tag_q;
        fsm_d      = fsm_q;
        kind_d     = kind_q;
        line_d     = line_q;
        mid_d      = mid_q;
        cur_buf_d  = cur_buf_q;
        miss_d     = miss_q;
        pend_d     = pend_q;
        pend_pf_d  = pend_pf_q;
        byp_d      = byp_q;
        pend_buf_d = pend_buf_q;
        rdy_d      = 1'b0;
        hit_d      = hit_q;
        fr_d       = 1'b0;
        fp_d       = fp_q;
        fl_d       = fl_q;
        fb_d       = fb_q;
        touch      = 1'b0;
        touch_idx  = '0;

        // a prefetch completing outside a waiting read: line parked as Prefetched
        if (fill_done && pend_q && pend_pf_q && fsm_q != FS_WAIT) begin
            st_d[pend_buf_q] = BS_PREFETCHED;
            pend_d           = 1'b0;
        end

        if (burst_end) begin
            for (int i = 0; i < NBUF; i++) begin
                if (st_d[i] == BS_BUSY_BUS) st_d[i] = BS_USED;
            end
        end

        if (!cfg_buf_en) begin
            for (int i = 0; i < NBUF; i++) st_d[i] = BS_INVALID;
        end

        unique case (fsm_q)
            FS_IDLE: begin
                if (req_valid) begin
                    kind_d = '{write: req_write, instr: req_instr, burst: req_burst};
                    line_d = req_line;
                    mid_d  = req_master;
                    if (req_write) begin
                        if (cfg_buf_en && hit_ok && !is_busy(st_q[hit_idx]))
                            st_d[hit_idx] = BS_INVALID;
                        rdy_d  = 1'b1;
                        hit_d  = 1'b0;
                        miss_d = 1'b0;
                        fsm_d  = FS_PF_CHECK;
                    end else if (!cfg_buf_en) begin
                        if (!pend_q) begin
                            fr_d      = 1'b1;
                            fl_d      = req_line;
                            fb_d      = '0;
                            fp_d      = 1'b0;
                            pend_d    = 1'b1;
                            pend_pf_d = 1'b0;
                            byp_d     = 1'b1;
                            miss_d    = 1'b1;
                            fsm_d     = FS_WAIT;
                        end
                    end else if (hit_ok) begin
                        miss_d = 1'b0;
                        if (st_q[hit_idx] == BS_BUSY_FILL && !fill_done) begin
                            cur_buf_d = hit_idx;
                            fsm_d     = FS_WAIT;
                        end else begin
                            st_d[hit_idx] = serve_state(req_burst);
                            touch         = 1'b1;
                            touch_idx     = hit_idx;
                            rdy_d         = 1'b1;
                            hit_d         = 1'b1;
                            fsm_d         = FS_PF_CHECK;
                        end
                    end else if (!pend_q && vict_ok) begin
                        tag_d[vict_idx] = req_line;
                        st_d[vict_idx]  = BS_BUSY_FILL;
                        fr_d            = 1'b1;
                        fl_d            = req_line;
                        fb_d            = vict_idx;
                        fp_d            = 1'b0;
                        pend_d          = 1'b1;
                        pend_pf_d       = 1'b0;
                        pend_buf_d      = vict_idx;
                        byp_d           = 1'b0;
                        cur_buf_d       = vict_idx;
                        miss_d          = 1'b1;
                        fsm_d           = FS_WAIT;
                    end
                end
            end

            FS_WAIT: begin
                if (fill_done) begin
                    pend_d = 1'b0;
                    rdy_d  = 1'b1;
                    fsm_d  = FS_PF_CHECK;
                    if (byp_q) begin
                        hit_d = 1'b0;
                    end else begin
                        hit_d = !miss_q;
                        if (cfg_buf_en) begin
                            st_d[cur_buf_q] = serve_state(kind_q.burst);
                            touch           = 1'b1;
                            touch_idx       = cur_buf_q;
                        end
                    end
                end
            end

            FS_PF_CHECK: begin
                fsm_d = FS_IDLE;
                if (pf_go && !nxt_ok && !pend_q && vict_ok) begin
                    tag_d[vict_idx] = nxt_line;
                    st_d[vict_idx]  = BS_BUSY_FILL;
                    fr_d            = 1'b1;
                    fl_d            = nxt_line;
                    fb_d            = vict_idx;
                    fp_d            = 1'b1;
                    pend_d          = 1'b1;
                    pend_pf_d       = 1'b1;
                    pend_buf_d      = vict_idx;
                    byp_d           = 1'b0;
                end
            end

            default: fsm_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) begin
                st_q[i]  <= BS_INVALID;
                tag_q[i] <= '0;
            end
            fsm_q      <= FS_IDLE;
            kind_q     <= '0;
            line_q     <= '0;
            mid_q      <= '0;
            cur_buf_q  <= '0;
            miss_q     <= 1'b0;
            pend_q     <= 1'b0;
            pend_pf_q  <= 1'b0;
            byp_q      <= 1'b0;
            pend_buf_q <= '0;
            rdy_q      <= 1'b0;
            hit_q      <= 1'b0;
            fr_q       <= 1'b0;
            fp_q       <= 1'b0;
            fl_q       <= '0;
            fb_q       <= '0;
        end else begin
            st_q       <= st_d;
            tag_q      <= tag_d;
            fsm_q      <= fsm_d;
            kind_q     <= kind_d;
            line_q     <= line_d;
            mid_q      <= mid_d;
            cur_buf_q  <= cur_buf_d;
            miss_q     <= miss_d;
            pend_q     <= pend_d;
            pend_pf_q  <= pend_pf_d;
            byp_q      <= byp_d;
            pend_buf_q <= pend_buf_d;
            rdy_q      <= rdy_d;
            hit_q      <= hit_d;
            fr_q       <= fr_d;
            fp_q       <= fp_d;
            fl_q       <= fl_d;
            fb_q       <= fb_d;
        end
    end

    assign req_ready = rdy_q;
    assign resp_hit  = hit_q;
    assign fill_req  = fr_q;
    assign fill_line = fl_q;
    assign fill_buf  = fb_q;
    assign fill_pf   = fp_q;

    a_r12_ready_single_cycle: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    a_r6_pf_requires_enables: assert property (@(posedge clk) disable iff (rst)
        fill_req && fill_pf |-> cfg_buf_en && (cfg_pf_limit != 2'd0));

    a_r7_no_pf_after_write: assert property (@(posedge clk) disable iff (rst)
        fill_req && fill_pf |-> !kind_q.write);

    a_r8_one_fill_in_flight: assert property (@(posedge clk) disable iff (rst)
        pend_q && !fill_done |=> !fill_req);

    a_r4_ready_after_fill_done: assert property (@(posedge clk) disable iff (rst)
        fsm_q == FS_WAIT && fill_done |=> req_ready);

    a_r2_target_marked_filling: assert property (@(posedge clk) disable iff (rst)
        fill_req && !byp_q && cfg_buf_en |-> st_q[fill_buf] == BS_BUSY_FILL);

    a_r1_hit_answer_without_fill: assert property (@(posedge clk) disable iff (rst)
        req_ready && resp_hit |-> !fill_req);

    a_r9_stall_while_engine_busy: assert property (@(posedge clk) disable iff (rst)
        fsm_q == FS_IDLE && req_valid && !req_write && cfg_buf_en && !hit_ok && pend_q
        |=> !fill_req && !req_ready);

endmodule

// File: tb/flbuf_ctrl_tb_top.sv
`timescale 1ns/1ps
module flbuf_ctrl_tb_top;
    localparam int NBUF   = 4;
    localparam int LINE_W = 8;
    localparam int MID_W  = 4;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_instr = 0, req_burst = 0;
    logic [LINE_W-1:0] req_line = '0;
    logic [MID_W-1:0]  req_master = '0;
    logic burst_end = 0;
    logic cfg_buf_en = 1;
    logic [1:0] cfg_pf_limit = 0;
    logic cfg_ipf_en = 0, cfg_dpf_en = 0;
    logic [15:0] cfg_master_pf = 16'hFFFF;
    logic fill_done = 0;
    logic req_ready, resp_hit, fill_req, fill_pf;
    logic [LINE_W-1:0] fill_line;
    logic [1:0] fill_buf;

    always #2.5 clk = ~clk;

    flbuf_ctrl #(.NBUF(NBUF), .LINE_W(LINE_W), .MID_W(MID_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
        .req_write(req_write), .req_instr(req_instr), .req_burst(req_burst),
        .req_master(req_master), .burst_end(burst_end), .cfg_buf_en(cfg_buf_en),
        .cfg_pf_limit(cfg_pf_limit), .cfg_ipf_en(cfg_ipf_en), .cfg_dpf_en(cfg_dpf_en),
        .cfg_master_pf(cfg_master_pf), .fill_done(fill_done), .req_ready(req_ready),
        .resp_hit(resp_hit), .fill_req(fill_req), .fill_line(fill_line),
        .fill_buf(fill_buf), .fill_pf(fill_pf)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;

    // array model and fill log
    int nf = 0, pend_cnt = 0;
    logic [LINE_W-1:0] fl_line [8];
    logic [1:0]        fl_buf  [8];
    logic              fl_pf   [8];

    always @(negedge clk) begin
        fill_done <= 1'b0;
        if (rst) begin
            pend_cnt = 0;
        end else begin
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) fill_done <= 1'b1;
            end
            if (fill_req) begin
                if (nf < 8) begin
                    fl_line[nf] = fill_line;
                    fl_buf[nf]  = fill_buf;
                    fl_pf[nf]   = fill_pf;
                end
                nf++;
                pend_cnt = LAT;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nf = 0;
    endtask

    bit auto_end = 1;

    task automatic xact(input logic [7:0] a, input bit w, input bit i, input bit b,
                        input logic [3:0] m, output bit got_hit, output int lat);
        @(negedge clk);
        req_valid = 1; req_line = a; req_write = w; req_instr = i;
        req_burst = b; req_master = m;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ready && lat < 500);
        got_hit   = resp_hit;
        req_valid = 0;
        if (b && !w && auto_end) begin
            burst_end = 1;
            @(negedge clk);
            burst_end = 0;
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    // ---------------- bench model of tags and recency ----------------
    logic [7:0] m_tag [4];
    bit         m_pres[4];
    int         m_ord [4];   // m_ord[0] most recent

    function automatic void m_reset();
        for (int k = 0; k < 4; k++) begin
            m_pres[k] = 0;
            m_tag[k] = 0;
            m_ord[k] = 3 - k;
        end
    endfunction

    function automatic int m_find(logic [7:0] a);
        for (int k = 0; k < 4; k++) if (m_pres[k] && m_tag[k] == a) return k;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int k = 0; k < 4; k++) if (!m_pres[k]) return k;
        return m_ord[3];
    endfunction

    function automatic void m_touch(int b);
        int p;
        p = 3;
        for (int k = 0; k < 4; k++) if (m_ord[k] == b) p = k;
        for (int k = p; k > 0; k--) m_ord[k] = m_ord[k-1];
        m_ord[0] = b;
    endfunction

    function automatic bit m_pf(bit miss, bit w, bit i, logic [3:0] m);
        bit typ, lim;
        typ = i ? cfg_ipf_en : cfg_dpf_en;
        lim = (cfg_pf_limit == 2'd1) ? miss : (cfg_pf_limit >= 2'd2);
        return cfg_buf_en && !w && typ && lim && cfg_master_pf[m];
    endfunction

    task automatic model_xact(input logic [7:0] a, input bit w, input bit i,
                              input bit b, input logic [3:0] m);
        int  e_n, h, v, v2;
        bit  e_hit, got, miss;
        int  lat;
        logic [7:0] e_line [2];
        int  e_buf [2];
        bit  e_pf [2];
        string rq [2];
        e_n = 0; e_hit = 0; miss = 0;
        if (w) begin
            h = m_find(a);
            if (h >= 0) m_pres[h] = 0;
        end else if (!cfg_buf_en) begin
            e_line[0] = a; e_buf[0] = 0; e_pf[0] = 0; rq[0] = "R10"; e_n = 1;
        end else begin
            h = m_find(a);
            if (h >= 0) begin
                e_hit = 1;
                m_touch(h);
            end else begin
                miss = 1;
                v = m_victim();
                rq[0] = m_pres[v] ? "R3" : "R2";
                e_line[0] = a; e_buf[0] = v; e_pf[0] = 0; e_n = 1;
                m_tag[v] = a; m_pres[v] = 1;
                m_touch(v);
            end
            if (m_pf(miss, w, i, m) && m_find(a + 8'd1) < 0) begin
                v2 = m_victim();
                e_line[e_n] = a + 8'd1; e_buf[e_n] = v2; e_pf[e_n] = 1;
                rq[e_n] = "R6"; e_n++;
                m_tag[v2] = a + 8'd1; m_pres[v2] = 1;
            end
        end
        nf = 0;
        xact(a, w, i, b, m, got, lat);
        settle();
        check(got == e_hit, e_hit ? "R1 hit flag" : "R4 miss flag", got, e_hit);
        if (w) check(lat == 1, "R7 write ack", lat, 1);
        else if (e_hit) check(lat == 1, "R1 hit latency", lat, 1);
        else check(lat == LAT + 2, "R4 fill latency", lat, LAT + 2);
        check(nf == e_n, "R6/R13 fill count", nf, e_n);
        for (int k = 0; k < 2; k++) begin
            if (k < e_n && k < nf) begin
                check(fl_line[k] == e_line[k], {rq[k], " fill line"}, fl_line[k], e_line[k]);
                check(fl_pf[k] == e_pf[k], {rq[k], " fill kind"}, fl_pf[k], e_pf[k]);
                if (cfg_buf_en)
                    check(fl_buf[k] == 2'(e_buf[k]), {rq[k], " fill buffer"}, fl_buf[k], e_buf[k]);
            end
        end
    endtask

    task automatic set_cfg(input int p);
        cfg_buf_en    = (p != 5);
        cfg_pf_limit  = 2'(p % 4);
        cfg_ipf_en    = (p != 4);
        cfg_dpf_en    = p[1];
        cfg_master_pf = p[0] ? 16'hFFFF : 16'h5A3C;
        @(negedge clk);
        if (!cfg_buf_en) for (int k = 0; k < 4; k++) m_pres[k] = 0;
    endtask

    initial begin
        bit got;
        int lat;
        logic [15:0] lfsr;
        logic [7:0]  a, prev;

        do_reset();
        // R12 reset state
        check(req_ready == 0, "R12 ready after reset", req_ready, 0);
        check(fill_req == 0, "R12 fill_req after reset", fill_req, 0);

        // R8: read the line whose prefetch is still in flight
        cfg_pf_limit = 1; cfg_ipf_en = 1; cfg_dpf_en = 0;
        nf = 0;
        xact(8'd40, 0, 1, 0, 4'd0, got, lat);
        xact(8'd41, 0, 1, 0, 4'd0, got, lat);
        settle();
        check(got == 1, "R8 busy-fill hit flag", got, 1);
        check(nf == 2, "R8 no second fill", nf, 2);
        check(fl_pf[1] == 1 && fl_line[1] == 8'd41, "R8 only the prefetch fill", fl_line[1], 41);

        // R9/R11/R2/R3: four open bursts, then a miss
        do_reset();
        cfg_pf_limit = 0;
        auto_end = 0;
        nf = 0;
        for (int k = 1; k <= 4; k++) xact(8'(k), 0, 0, 1, 4'd0, got, lat);
        check(nf == 4 && fl_buf[0] == 0 && fl_buf[3] == 3, "R2 lowest invalid order", fl_buf[3], 3);
        nf = 0;
        fork
            xact(8'd9, 0, 0, 0, 4'd0, got, lat);
            begin
                repeat (20) @(negedge clk);
                check(nf == 0, "R9/R11 no fill while all busy", nf, 0);
                check(req_ready == 0, "R9 ready held low", req_ready, 0);
                burst_end = 1;
                @(negedge clk);
                burst_end = 0;
            end
        join
        settle();
        check(nf == 1 && fl_buf[0] == 0, "R3 oldest buffer replaced", fl_buf[0], 0);
        auto_end = 1;

        // R5 scenario A: prefetched buffer never hit stays oldest
        for (int sc = 0; sc < 2; sc++) begin
            do_reset();
            cfg_pf_limit = 2; cfg_dpf_en = 1; cfg_ipf_en = 0;
            xact(8'd10, 0, 0, 0, 4'd2, got, lat);
            settle();
            cfg_pf_limit = 0;
            xact(8'd20, 0, 0, 0, 4'd2, got, lat);
            settle();
            xact(8'd30, 0, 0, 0, 4'd2, got, lat);
            settle();
            if (sc == 1) begin
                xact(8'd11, 0, 0, 0, 4'd2, got, lat);
                check(got == 1, "R5 prefetched line hits", got, 1);
            end
            nf = 0;
            xact(8'd50, 0, 0, 0, 4'd2, got, lat);
            settle();
            check(fl_buf[0] == ((sc == 0) ? 2'd1 : 2'd0), "R5 recency of prefetched buffer",
                  fl_buf[0], (sc == 0) ? 1 : 0);
        end

        // model-driven sweep
        do_reset();
        m_reset();
        lfsr = 16'hACE1;
        prev = 0;
        for (int p = 0; p < 8; p++) begin
            set_cfg(p);
            for (int t = 0; t < 50; t++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a = lfsr[4] ? prev + 8'd1 : 8'(lfsr[3:0] % 10);
                if (lfsr[15:12] == 4'd0) a = 8'hFF;
                model_xact(a, lfsr[7:5] == 3'd0, lfsr[8], lfsr[9], lfsr[13:10]);
                prev = a;
            end
        end
        finish_run();
    end

endmodule